// File: doc/BRIEF.md
# NOR Flash Command Interpreter Model

This block is a synthesizable behavioural model of the command state machine inside a parallel NOR flash. A host issues single-cycle write strobes (address plus 16-bit data) and single-cycle read strobes. The write strobes pass through an unlock-sequence decoder. Valid sequences start a word program, a sector erase, a whole-array erase, or entry to and exit from a product-identification mode. Any cycle that breaks a sequence throws the decoder back to idle, and nothing happens.

Program and erase operations occupy a timed busy window, built from parameterised cycle counts that are kept small for simulation. During that window the ready output is low, writes are ignored, and reads return polling status instead of array data. That status is the complement of bit 7 of the data being written, plus a bit 6 that flips on every read. A small on-chip array holds the contents and is divided into eight small and fifteen large sectors. A host-loaded protection mask keeps chosen sectors from being programmed or erased.

Top module: `nor_cmd_engine`

## Requirements
- R1: An erased word reads 16'hFFFF. A sector erase or array erase writes all ones to every word it covers.
- R2: A word program is four writes: 8'hAA to address 11'h555, then 8'h55 to 11'h2AA, then 8'hA0 to 11'h555, then the target address with its data. The stored word becomes old AND new, so bits only go from 1 to 0. Command matching uses the low 8 data bits and the low 11 address bits.
- R3: An erase is six writes: AA@555, 55@2AA, 80@555, AA@555, 55@2AA. The sixth write selects the kind. 8'h30 at any address inside a sector erases that sector only. 8'h10 at 11'h555 erases every unprotected sector.
- R4: A write whose address or data does not match the expected step sends the decoder back to idle. No operation starts, `rdy` stays 1, and the array is unchanged.
- R5: `rdy` goes low on the cycle after the program data write and stays low for exactly PROG_CYCLES cycles. An erase keeps `rdy` low while it sweeps all 2^ADDR_W words, plus ERASE_CYCLES more cycles.
- R6: A read issued while busy returns a status word. Bit 7 is the inverse of bit 7 of the program data, which is 0 during an erase. Bit 6 is 0 for the first busy read after reset and inverts on each later busy read. All other bits are 0.
- R7: Writes issued while `rdy` is 0 are ignored. They neither start an operation nor advance the decoder.
- R8: A `lock_we` strobe loads `lock_mask`, where bit i protects sector i. A program or sector erase aimed at a protected sector ends at once: `rdy` stays 1 and no data changes. An array erase leaves protected sectors intact.
- R9: With the default bottom-boot layout and ADDR_W=11, sectors 0 to 7 are 16 words each and cover 11'h000 to 11'h07F. Sectors 8 to 22 are 128 words each, so sector 8 covers 11'h080 to 11'h0FF. With TOP_BOOT=1 the small sectors sit at the top of the address space instead.
- R10: 8'h90 as the third write (to 11'h555) enters ID mode. In ID mode, reads at address 0 return 16'h001F, reads at address 1 return 16'h00C1 (16'h00C3 when TOP_BOOT=1), and reads at any other address return 0. Writing 8'hF0 to any address exits ID mode, except when the decoder is waiting for program data.
- R11: After reset, `rdy` is 1, `rvalid` is 0, ID mode is off, no sector is protected and the decoder is idle. Every read strobe gives `rvalid` high with its data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one command cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data |
| lock_we | input | 1 | Load strobe for the protection mask |
| lock_mask | input | 23 | Protection bit per sector |
| rdata | output | 16 | Read data or status, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| rdy | output | 1 | 1 when idle, 0 while a program or erase runs |

## Verification
A decoder left in the wrong step is visible only on a later write. A correct sequence then fails to start (`rdy` stays high) or a stray write starts an operation. A read-back on the cycle after the busy window exposes the resulting array damage. Wrong sector decoding shows up after an erase, as neighbouring words that were wiped or target words that survived. A bad busy counter shows up as a `rdy` low time that differs from PROG_CYCLES. The toggle bit is modelled in the bench across every busy read, so a missed or extra flip gives a miscompare on the very next status read.

// File: rtl/nor_pkg.sv
package nor_pkg;
    localparam int SMALL_SECTS = 8;
    localparam int LARGE_SECTS = 15;
    localparam int LARGE_RATIO = 8;
    localparam int UNIT_CNT    = SMALL_SECTS + LARGE_SECTS * LARGE_RATIO;
    localparam int UNIT_W      = $clog2(UNIT_CNT);
    localparam int NUM_SECTS   = SMALL_SECTS + LARGE_SECTS;
    localparam int SECT_W      = $clog2(NUM_SECTS);

    localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_A        = 8'hAA;
    localparam logic [7:0]  KEY_B        = 8'h55;
    localparam logic [7:0]  OP_PROGRAM   = 8'hA0;
    localparam logic [7:0]  OP_ERASE     = 8'h80;
    localparam logic [7:0]  OP_SECT      = 8'h30;
    localparam logic [7:0]  OP_CHIP      = 8'h10;
    localparam logic [7:0]  OP_ID_ON     = 8'h90;
    localparam logic [7:0]  OP_ID_OFF    = 8'hF0;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_PROG, CMD_SERASE, CMD_CERASE, CMD_ID_ON, CMD_ID_OFF
    } cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3
    } seq_e;
endpackage

// File: rtl/nor_sector_map.sv
module nor_sector_map
    import nor_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [UNIT_W-1:0] unit,
    output logic [SECT_W-1:0] sect
);
    localparam int LARGE_UNITS = LARGE_SECTS * LARGE_RATIO;

    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (int'(unit) < LARGE_UNITS)
                    sect = SECT_W'(int'(unit) / LARGE_RATIO);
                else
                    sect = SECT_W'(LARGE_SECTS + int'(unit) - LARGE_UNITS);
            end
        end else begin : g_bottom
            always_comb begin
                if (int'(unit) < SMALL_SECTS)
                    sect = SECT_W'(int'(unit));
                else
                    sect = SECT_W'(SMALL_SECTS + (int'(unit) - SMALL_SECTS) / LARGE_RATIO);
            end
        end
    endgenerate
endmodule

// File: rtl/nor_seq_decoder.sv
module nor_seq_decoder
    import nor_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cmd_e              cmd
);
    typedef struct packed {
        seq_e st;
    } seq_t;

    seq_t q, d;
    logic [10:0] a11;
    logic [7:0]  key;

    assign a11 = addr[10:0];
    assign key = wdata[7:0];

    always_comb begin
        d   = q;
        cmd = CMD_NONE;
        if (wr_en && !busy) begin
            if (key == OP_ID_OFF && q.st != SQ_PGM) begin
                cmd  = CMD_ID_OFF;
                d.st = SQ_IDLE;
            end else begin
                d.st = SQ_IDLE;
                unique case (q.st)
                    SQ_IDLE: if (a11 == UNLOCK_ADDR_A && key == KEY_A) d.st = SQ_U1;
                    SQ_U1:   if (a11 == UNLOCK_ADDR_B && key == KEY_B) d.st = SQ_U2;
                    SQ_U2: begin
                        if (a11 == UNLOCK_ADDR_A) begin
                            if (key == OP_PROGRAM)    d.st = SQ_PGM;
                            else if (key == OP_ERASE) d.st = SQ_E1;
                            else if (key == OP_ID_ON) cmd  = CMD_ID_ON;
                        end
                    end
                    SQ_PGM:  cmd = CMD_PROG;
                    SQ_E1:   if (a11 == UNLOCK_ADDR_A && key == KEY_A) d.st = SQ_E2;
                    SQ_E2:   if (a11 == UNLOCK_ADDR_B && key == KEY_B) d.st = SQ_E3;
                    SQ_E3: begin
                        if (key == OP_SECT)
                            cmd = CMD_SERASE;
                        else if (key == OP_CHIP && a11 == UNLOCK_ADDR_A)
                            cmd = CMD_CERASE;
                    end
                    default: d.st = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_IDLE};
        else        q <= d;
    end
endmodule

// File: rtl/nor_array.sv
module nor_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20,
    parameter bit TOP_BOOT     = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [15:0]          wdata,
    input  logic                 lock_we,
    input  logic [NUM_SECTS-1:0] lock_mask,
    output logic [15:0]          rdata,
    output logic                 rvalid,
    output logic                 rdy
);
    localparam int DATA_W   = 16;
    localparam int MAX_CNT  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);
    localparam logic [DATA_W-1:0] MFR_CODE = 16'h001F;
    localparam logic [DATA_W-1:0] DEV_CODE = TOP_BOOT ? 16'h00C3 : 16'h00C1;

    typedef struct packed {
        logic                 busy;
        logic                 sweeping;
        logic                 chip;
        logic [SECT_W-1:0]    tgt;
        logic [CNT_W-1:0]     cnt;
        logic [ADDR_W-1:0]    ptr;
        logic [DATA_W-1:0]    pdata;
        logic                 tog;
        logic                 id;
        logic [NUM_SECTS-1:0] lock;
        logic                 rvalid;
        logic [DATA_W-1:0]    rdata;
    } eng_t;

    eng_t q, d;

    cmd_e              cmd;
    logic [SECT_W-1:0] cmd_sect;
    logic [SECT_W-1:0] ptr_sect;
    logic              cmd_valid;
    logic              cmd_is_prog;
    logic              cmd_locked;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] rd_host;
    logic [DATA_W-1:0] rd_old;

    nor_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .busy  (q.busy),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    nor_sector_map #(.TOP_BOOT(TOP_BOOT)) u_map_cmd (
        .unit (addr[ADDR_W-1 -: UNIT_W]),
        .sect (cmd_sect)
    );

    nor_sector_map #(.TOP_BOOT(TOP_BOOT)) u_map_sweep (
        .unit (q.ptr[ADDR_W-1 -: UNIT_W]),
        .sect (ptr_sect)
    );

    nor_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (addr),
        .rdata_a (rd_host),
        .raddr_b (addr),
        .rdata_b (rd_old)
    );

    assign cmd_valid   = (cmd != CMD_NONE);
    assign cmd_is_prog = (cmd == CMD_PROG);
    assign cmd_locked  = q.lock[cmd_sect];

    always_comb begin
        d         = q;
        d.rvalid  = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = addr;
        mem_wdata = rd_old & wdata;

        if (lock_we) d.lock = lock_mask;

        if (q.busy) begin
            if (q.sweeping) begin
                if ((q.chip && !q.lock[ptr_sect]) || (!q.chip && ptr_sect == q.tgt)) begin
                    mem_we    = 1'b1;
                    mem_waddr = q.ptr;
                    mem_wdata = '1;
                end
                if (q.ptr == '1) begin
                    d.sweeping = 1'b0;
                    d.cnt      = CNT_W'(ERASE_CYCLES - 1);
                end else begin
                    d.ptr = q.ptr + 1'b1;
                end
            end else if (q.cnt == '0) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else begin
            unique case (cmd)
                CMD_PROG: begin
                    if (!cmd_locked) begin
                        mem_we     = 1'b1;
                        d.busy     = 1'b1;
                        d.sweeping = 1'b0;
                        d.cnt      = CNT_W'(PROG_CYCLES - 1);
                        d.pdata    = wdata;
                    end
                end
                CMD_SERASE, CMD_CERASE: begin
                    if (cmd == CMD_CERASE || !cmd_locked) begin
                        d.busy     = 1'b1;
                        d.sweeping = 1'b1;
                        d.ptr      = '0;
                        d.chip     = (cmd == CMD_CERASE);
                        d.tgt      = cmd_sect;
                        d.pdata    = '1;
                    end
                end
                CMD_ID_ON:  d.id = 1'b1;
                CMD_ID_OFF: d.id = 1'b0;
                default: ;
            endcase
        end

        if (rd_en) begin
            d.rvalid = 1'b1;
            if (q.busy) begin
                d.rdata    = '0;
                d.rdata[7] = ~q.pdata[7];
                d.rdata[6] = q.tog;
                d.tog      = ~q.tog;
            end else if (q.id) begin
                if (addr == ADDR_W'(0))      d.rdata = MFR_CODE;
                else if (addr == ADDR_W'(1)) d.rdata = DEV_CODE;
                else                         d.rdata = '0;
            end else begin
                d.rdata = rd_host;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;
    assign rdy    = ~q.busy;
endmodule

// File: rtl/nor_cmd_checker.sv
module nor_cmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic        rdy,
    input logic        rvalid,
    input logic [15:0] rdata,
    input logic        cmd_valid,
    input logic        cmd_is_prog,
    input logic        cmd_locked,
    input logic        mem_we,
    input logic [15:0] mem_wdata
);
    // R11: read strobe answered one cycle later
    p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    p_no_spurious_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    // R7: decoder raises no command while busy
    p_busy_blocks_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !cmd_valid);
    // R8: no array write for a program on a protected sector
    p_locked_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_prog && cmd_locked) |-> !mem_we);
    // R6: busy-time reads carry only the two status bits
    p_status_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !$past(rdy)) |-> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));
    // R5: busy only starts from a write cycle
    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(wr_en));
    // R1: array writes during busy are erase fills of all ones
    p_erase_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !rdy) |-> (mem_wdata == 16'hFFFF));
endmodule

bind nor_cmd_engine nor_cmd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rdy         (rdy),
    .rvalid      (rvalid),
    .rdata       (rdata),
    .cmd_valid   (cmd_valid),
    .cmd_is_prog (cmd_is_prog),
    .cmd_locked  (cmd_locked),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata)
);

// File: tb/nor_cmd_engine_tb.sv
`timescale 1ns/1ps
module nor_cmd_engine_tb;
    localparam int AW    = 11;
    localparam int PROG  = 8;
    localparam int ERASE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        lock_we = 1'b0;
    logic [22:0] lock_mask = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic        rdy;

    int n_vec = 0;
    int n_bad = 0;
    logic tb_tog = 1'b0;

    logic [15:0] exp_q [$];
    logic [15:0] msk_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    nor_cmd_engine #(.ADDR_W(AW), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .lock_we(lock_we), .lock_mask(lock_mask),
        .rdata(rdata), .rvalid(rvalid), .rdy(rdy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // monitor: pop expected item for every returned read
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected rvalid", int'(rdata), 0);
            end else begin
                logic [15:0] e, m;
                string t;
                e = exp_q.pop_front();
                m = msk_q.pop_front();
                t = tag_q.pop_front();
                check((rdata & m) == (e & m), t, int'(rdata & m), int'(e & m));
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] dv);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = dv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); msk_q.push_back(16'hFFFF); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // busy-time read: expected status from R6
    task automatic rd_status(input logic bit7_src, input string t);
        rd(11'h000, {8'h00, ~bit7_src, tb_tog, 6'h00}, t);
        tb_tog = ~tb_tog;
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [15:0] dv);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(a, dv);
    endtask

    task automatic erase_pre();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
    endtask

    task automatic wait_ready(input string t);
        int n = 0;
        while (!rdy && n < 6000) begin
            @(negedge clk);
            n++;
        end
        check(rdy == 1'b1, t, int'(rdy), 1);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy == 1'b1, "R11 reset rdy", int'(rdy), 1);
        check(rvalid == 1'b0, "R11 reset rvalid", int'(rvalid), 0);

        // array erase, status read and ignored writes during busy
        erase_pre();
        wr(11'h555, 16'h0010);
        check(rdy == 1'b0, "R3 chip erase starts busy", int'(rdy), 0);
        rd_status(1'b1, "R6 erase status");
        prog(11'h070, 16'h0000);   // R7: must be ignored
        rd_status(1'b1, "R6 erase status toggled");
        wait_ready("R5 erase completes");
        rd(11'h000, 16'hFFFF, "R1 erased low word");
        rd(11'h7FF, 16'hFFFF, "R1 erased top word");
        rd(11'h070, 16'hFFFF, "R7 write during busy ignored");

        // program and busy length
        prog(11'h050, 16'hA5C3);
        begin
            int n = 0;
            while (!rdy && n < 100) begin
                n++;
                @(negedge clk);
            end
            check(n == PROG, "R5 program busy length", n, PROG);
        end
        rd(11'h050, 16'hA5C3, "R2 program data");
        prog(11'h050, 16'hFF0F);
        wait_ready("R5 program ends");
        rd(11'h050, 16'hA503, "R2 program only clears bits");

        prog(11'h040, 16'h3C7E);
        rd_status(1'b0, "R6 program status bit7");
        rd_status(1'b0, "R6 program status toggle");
        wait_ready("R5 program ends");
        rd(11'h040, 16'h3C7E, "R2 second sector data");
        prog(11'h090, 16'h1234);
        wait_ready("R5 program ends");

        // broken sequences
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h554, 16'h00A0);
        wr(11'h060, 16'h0000);
        check(rdy == 1'b1, "R4 wrong address no busy", int'(rdy), 1);
        rd(11'h060, 16'hFFFF, "R4 wrong address no program");
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0054);
        prog(11'h061, 16'h0F0F);
        wait_ready("R4 restart after wrong data");
        rd(11'h061, 16'h0F0F, "R4 valid sequence after reject");

        // sector erase of sector 5 (R9: 11'h050 small sector)
        erase_pre();
        wr(11'h050, 16'h0030);
        check(rdy == 1'b0, "R3 sector erase busy", int'(rdy), 0);
        wait_ready("R5 sector erase ends");
        rd(11'h050, 16'hFFFF, "R3 target sector erased");
        rd(11'h040, 16'h3C7E, "R9 neighbour small sector kept");
        rd(11'h061, 16'h0F0F, "R9 sector 6 kept");
        rd(11'h090, 16'h1234, "R9 large sector kept");

        // protection of sector 8
        @(negedge clk);
        lock_we = 1'b1; lock_mask = 23'h000100;
        @(negedge clk);
        lock_we = 1'b0;
        erase_pre();
        wr(11'h0F0, 16'h0030);
        check(rdy == 1'b1, "R8 protected erase ends at once", int'(rdy), 1);
        rd(11'h090, 16'h1234, "R8 protected sector kept");
        prog(11'h095, 16'h0000);
        check(rdy == 1'b1, "R8 protected program no busy", int'(rdy), 1);
        rd(11'h095, 16'hFFFF, "R8 protected program no change");
        erase_pre();
        wr(11'h555, 16'h0010);
        wait_ready("R5 chip erase ends");
        rd(11'h090, 16'h1234, "R8 chip erase skips protected");
        rd(11'h040, 16'hFFFF, "R3 chip erase clears unprotected");
        rd(11'h061, 16'hFFFF, "R3 chip erase clears sector 6");

        // product ID
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h0090);
        rd(11'h000, 16'h001F, "R10 manufacturer code");
        rd(11'h001, 16'h00C1, "R10 device code");
        rd(11'h090, 16'h0000, "R10 other offset");
        wr(11'h123, 16'h00F0);
        rd(11'h090, 16'h1234, "R10 exit restores array");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule